// File: doc/BRIEF.md
# Audio Master Clock Ratio Divider

This block derives the master clock for an external audio converter, together with the bit-rate and frame-rate timing pulses for a serial audio port, from one fast core clock. The core clock runs at twice the root audio clock. For the 512x family the root is 512 times the sample rate fs, so the core runs at 1024·fs. For the 384x family the root is 384·fs, so the core runs at 768·fs. The master clock is a registered square wave. Its half period is 2^code core cycles, so code 0 reproduces the root rate and each higher code halves it.

A family select input chooses the 512x or 384x ratio set. A 3-bit code picks a power-of-two sub-rate inside that family. A code that does not belong to the selected family keeps the master clock low. A new code is picked up only at the end of a low phase, so the output never carries a shortened pulse.

The bit tick and the frame tick run from the core clock and do not depend on the code. Both families give 16 core cycles per bit: 64 bits per frame in the 512x family and 48 in the 384x family. The block runs while the run input is high and the gate input is low. Gate overrides run.

Top module: `audio_mclk_divider`

## Requirements
- R1: After a synchronous active-low reset, and while run stays low, `mclk_out`, `bclk_tick` and `frame_tick` are all 0.
- R2: With `base_sel`=0 (512x family), codes 0 to 4 give a master clock whose high and low phases each last 2^code core cycles. The resulting ratios are 512, 256, 128, 64 and 32 times fs.
- R3: With `base_sel`=1 (384x family), codes 0 to 3 give high and low phases of 2^code core cycles each. The resulting ratios are 384, 192, 96 and 48 times fs.
- R4: Codes 5 to 7 with `base_sel`=0, and codes 4 to 7 with `base_sel`=1, keep `mclk_out` low once the current period has ended.
- R5: A code change made during a high phase leaves that high phase and the low phase after it at the old length. The new length applies from the next rising edge.
- R6: When run is low on a clock edge, all three outputs are 0 after that edge and stay 0 while run stays low.
- R7: When gate is high on a clock edge, all three outputs are 0 after that edge, whatever the value of run.
- R8: While enabled, `bclk_tick` is a one-cycle pulse every 16 core cycles. The first pulse is visible after the 16th enabled edge.
- R9: `frame_tick` only coincides with a `bclk_tick` pulse. It marks every 64th bit (a 1024-cycle frame) in the 512x family and every 48th bit (a 768-cycle frame) in the 384x family.
- R10: The frame length follows the `base_sel` value captured while stopped, or captured at the edge that issues a frame tick. A change made mid-frame only affects the following frame.
- R11: When the block is enabled from a stopped state with a legal code, `mclk_out` is high after the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the root audio clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables the outputs while high |
| gate | input | 1 | Forces all outputs off while high |
| base_sel | input | 1 | 0 selects the 512x family, 1 selects the 384x family |
| mult_code | input | 3 | Power-of-two sub-rate code |
| mclk_out | output | 1 | Master clock output |
| bclk_tick | output | 1 | One-cycle pulse per serial bit |
| frame_tick | output | 1 | One-cycle pulse per audio frame |

## Verification
The bench measures every legal code in both families, and a wrong divide would show up as a phase length other than 2^code. It steps through the codes that are illegal only in one family, such as code 4 with the 384x family, where a lax legality decode would let the clock toggle. It changes the code in the middle of a high phase; a design that applied the change at once would produce a truncated 2-cycle high pulse instead of finishing the 8-cycle phase. It switches the family select in the middle of a frame and at a frame boundary; a design that sampled the select continuously would end the running frame early.

// File: rtl/mclk_div_pkg.sv
// Package: shared types and helpers for the audio master clock divider.
// Assumes codes are compared as unsigned integers.
package mclk_div_pkg;

    // Ratio family selected by the base select input.
    typedef enum logic {
        FAM_512 = 1'b0,
        FAM_384 = 1'b1
    } fam_e;

    // True when a sub-rate code belongs to the chosen family.
    function automatic logic code_legal(input fam_e fam, input int unsigned code,
                                        input int unsigned max512, input int unsigned max384);
        if (fam == FAM_384)
            return code <= max384;
        else
            return code <= max512;
    endfunction

endpackage

// File: rtl/mclk_phase_gen.sv
// Module: mclk_phase_gen
// Produces the master clock as a registered square wave whose half period
// is 2^code core cycles. The code is captured only when a low phase ends,
// and an illegal code keeps the output low. Assumes en is already the
// combination of run and gate.
module mclk_phase_gen
    import mclk_div_pkg::*;
#(
    parameter int CODE_W       = 3,
    parameter int MAX_CODE_512 = 4,
    parameter int MAX_CODE_384 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              base_sel,
    input  logic [CODE_W-1:0] code_req,
    output logic              mclk
);

    localparam int CNT_W = MAX_CODE_512 + 1;

    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] cur;
    logic              mclk_q;
    logic              req_ok;
    logic              at_edge;

    // Half period minus one, for a given code.
    function automatic logic [CNT_W-1:0] half_m1(input logic [CODE_W-1:0] c);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        return (one << c) - one;
    endfunction

    // Legality of the requested code in the chosen family.
    assign req_ok  = code_legal(fam_e'(base_sel), int'(unsigned'(code_req)),
                                MAX_CODE_512, MAX_CODE_384);
    assign at_edge = (cnt == '0);

    // Phase counter and output toggle; the code is loaded only at a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mclk_q <= 1'b0;
            cnt    <= '0;
            cur    <= '0;
        end else if (!en) begin
            mclk_q <= 1'b0;
            cnt    <= '0;
        end else if (at_edge) begin
            if (mclk_q) begin
                mclk_q <= 1'b0;
                cnt    <= half_m1(cur);
            end else if (req_ok) begin
                mclk_q <= 1'b1;
                cur    <= code_req;
                cnt    <= half_m1(code_req);
            end
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign mclk = mclk_q;

    // R6: stopping forces the clock low on the next edge.
    assert_stop_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mclk);

    // R4: a rising edge only follows a legal request.
    assert_rise_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk) |-> $past(req_ok));

    // R5: the active code never moves while the clock stays high.
    assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk && $past(mclk)) |-> $stable(cur));

endmodule

// File: rtl/bit_tick_gen.sv
// Module: bit_tick_gen
// Divides the core clock down to the serial bit rate and emits a one-cycle
// tick per bit. Also exposes the combinational wrap condition so that the
// frame counter can align to it. Assumes BIT_DIV >= 2.
module bit_tick_gen #(
    parameter int BIT_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic wrap,
    output logic tick
);

    localparam int BW = $clog2(BIT_DIV);

    logic [BW-1:0] cnt;

    assign wrap = en && (cnt == BW'(BIT_DIV - 1));

    // Bit-period counter with a registered tick on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            cnt  <= wrap ? '0 : cnt + 1'b1;
            tick <= wrap;
        end
    end

    // R8: the tick lasts exactly one cycle.
    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R6: no tick once the block is stopped.
    assert_tick_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);

endmodule

// File: rtl/frame_tick_gen.sv
// Module: frame_tick_gen
// Counts bit wraps and emits a frame tick on the last bit of each frame.
// The frame length follows the family captured while stopped or at each
// frame boundary. Assumes bit_wrap comes from bit_tick_gen.
module frame_tick_gen
    import mclk_div_pkg::*;
#(
    parameter int BITS_512 = 64,
    parameter int BITS_384 = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic base_sel,
    input  logic bit_wrap,
    output logic tick
);

    localparam int MAXB = (BITS_512 > BITS_384) ? BITS_512 : BITS_384;
    localparam int FW   = $clog2(MAXB);

    fam_e          fam_q;
    logic [FW-1:0] fcnt;
    logic [FW-1:0] limit_m1;
    logic          last;

    assign limit_m1 = (fam_q == FAM_384) ? FW'(BITS_384 - 1) : FW'(BITS_512 - 1);
    assign last     = bit_wrap && (fcnt == limit_m1);

    // Bit-in-frame counter, family capture and frame tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt  <= '0;
            tick  <= 1'b0;
            fam_q <= FAM_512;
        end else if (!en) begin
            fcnt  <= '0;
            tick  <= 1'b0;
            fam_q <= fam_e'(base_sel);
        end else begin
            tick <= last;
            if (bit_wrap)
                fcnt <= last ? '0 : fcnt + 1'b1;
            if (last)
                fam_q <= fam_e'(base_sel);
        end
    end

    // R9: consecutive frame ticks never occur.
    assert_frame_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/audio_mclk_divider.sv
// Module: audio_mclk_divider (top)
// Derives the converter master clock, the bit tick and the frame tick from
// a core clock running at twice the root audio clock. Run enables the
// outputs and gate overrides it. Assumes all inputs are synchronous to clk.
module audio_mclk_divider #(
    parameter int CODE_W       = 3,
    parameter int MAX_CODE_512 = 4,
    parameter int MAX_CODE_384 = 3,
    parameter int BIT_DIV      = 16,
    parameter int BITS_512     = 64,
    parameter int BITS_384     = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              gate,
    input  logic              base_sel,
    input  logic [CODE_W-1:0] mult_code,
    output logic              mclk_out,
    output logic              bclk_tick,
    output logic              frame_tick
);

    logic en;
    logic bit_wrap;

    // Gate has priority over run.
    assign en = run & ~gate;

    mclk_phase_gen #(
        .CODE_W       (CODE_W),
        .MAX_CODE_512 (MAX_CODE_512),
        .MAX_CODE_384 (MAX_CODE_384)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .base_sel (base_sel),
        .code_req (mult_code),
        .mclk     (mclk_out)
    );

    bit_tick_gen #(
        .BIT_DIV (BIT_DIV)
    ) u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .wrap  (bit_wrap),
        .tick  (bclk_tick)
    );

    frame_tick_gen #(
        .BITS_512 (BITS_512),
        .BITS_384 (BITS_384)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .base_sel (base_sel),
        .bit_wrap (bit_wrap),
        .tick     (frame_tick)
    );

    // R7: gate silences every output on the next edge.
    assert_gate_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> (!mclk_out && !bclk_tick && !frame_tick));

    // R9: a frame tick always lands on a bit tick.
    assert_frame_on_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> bclk_tick);

endmodule

// File: tb/sim_audio_mclk_divider.sv
module sim_audio_mclk_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       gate = 1'b0;
    logic       base_sel = 1'b0;
    logic [2:0] code = 3'd0;
    logic       mclk, btick, ftick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { int half; string tag; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    audio_mclk_divider u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .gate(gate), .base_sel(base_sel),
        .mult_code(code), .mclk_out(mclk), .bclk_tick(btick), .frame_tick(ftick)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: measures each full master clock period and scores it.
    initial begin
        logic prev;
        int hi_n, lo_n;
        bit seen_fall;
        exp_t e;
        prev = 1'b0; hi_n = 0; lo_n = 0; seen_fall = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev = 1'b0; hi_n = 0; lo_n = 0; seen_fall = 1'b0;
            end else begin
                if (mclk && !prev) begin
                    if (seen_fall && exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        check_eq(e.tag, hi_n, e.half);
                        check_eq(e.tag, lo_n, e.half);
                    end
                    hi_n = 1; lo_n = 0; seen_fall = 1'b0;
                end else if (mclk && prev) begin
                    hi_n++;
                end else if (!mclk && prev) begin
                    seen_fall = 1'b1; lo_n = 1;
                end else begin
                    lo_n++;
                end
                prev = mclk;
            end
        end
    end

    task automatic measure_phase(input logic lvl, output int n);
        n = 0;
        while (mclk == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic frame_period(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ftick);
    endtask

    task automatic count_active(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (mclk || btick || ftick) n++;
        end
    endtask

    // Driver
    initial begin
        int n, first_m, first_b, first_f;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 mclk", mclk, 0);
        check_eq("R1 bclk", btick, 0);
        check_eq("R1 frame", ftick, 0);
        count_active(20, n);
        check_eq("R1 idle", n, 0);

        // R11, R8, R9, R10: start with 512x, switch family mid-frame
        base_sel = 1'b0; code = 3'd2; run = 1'b1;
        first_m = 0; first_b = 0; first_f = 0;
        for (int j = 1; j <= 1024; j++) begin
            @(negedge clk);
            if (j == 100) base_sel = 1'b1;
            if (mclk && first_m == 0) first_m = j;
            if (btick && first_b == 0) first_b = j;
            if (ftick && first_f == 0) first_f = j;
        end
        check_eq("R11 first rise", first_m, 1);
        check_eq("R8 first bit", first_b, 16);
        check_eq("R10 frame kept", first_f, 1024);
        frame_period(n);
        check_eq("R9 384 frame", n, 768);
        base_sel = 1'b0;
        frame_period(n);
        check_eq("R10 boundary", n, 768);
        frame_period(n);
        check_eq("R9 512 frame", n, 1024);

        // R8: bit period and pulse width
        while (!btick) @(negedge clk);
        @(negedge clk);
        check_eq("R8 width", btick, 0);
        n = 1;
        while (!btick) begin @(negedge clk); n++; end
        check_eq("R8 period", n, 16);

        // R2, R3: every legal code through the scoreboard
        for (int c = 0; c <= 4; c++) begin
            base_sel = 1'b0; code = 3'(c);
            repeat (256) @(negedge clk);
            exp_q.push_back('{half: 1 << c, tag: "R2"});
            repeat (128) @(negedge clk);
        end
        for (int c = 0; c <= 3; c++) begin
            base_sel = 1'b1; code = 3'(c);
            repeat (256) @(negedge clk);
            exp_q.push_back('{half: 1 << c, tag: "R3"});
            repeat (128) @(negedge clk);
        end
        check_eq("R2 R3 drained", exp_q.size(), 0);

        // R4: illegal codes per family
        for (int c = 4; c <= 7; c++) begin
            base_sel = 1'b1; code = 3'(c);
            repeat (64) @(negedge clk);
            n = 0;
            for (int i = 0; i < 200; i++) begin @(negedge clk); if (mclk) n++; end
            check_eq("R4 384 illegal", n, 0);
        end
        for (int c = 5; c <= 7; c++) begin
            base_sel = 1'b0; code = 3'(c);
            repeat (64) @(negedge clk);
            n = 0;
            for (int i = 0; i < 200; i++) begin @(negedge clk); if (mclk) n++; end
            check_eq("R4 512 illegal", n, 0);
        end

        // R5: code change inside a high phase
        base_sel = 1'b0; code = 3'd3;
        repeat (64) @(negedge clk);
        while (mclk) @(negedge clk);
        while (!mclk) @(negedge clk);
        @(negedge clk);
        code = 3'd1;
        measure_phase(1'b1, n);
        check_eq("R5 old high", n + 1, 8);
        measure_phase(1'b0, n);
        check_eq("R5 old low", n, 8);
        measure_phase(1'b1, n);
        check_eq("R5 new high", n, 2);
        measure_phase(1'b0, n);
        check_eq("R5 new low", n, 2);

        // R6: run low stops everything
        code = 3'd2;
        repeat (40) @(negedge clk);
        while (!mclk) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check_eq("R6 mclk", mclk, 0);
        count_active(300, n);
        check_eq("R6 held", n, 0);
        run = 1'b1;
        @(negedge clk);
        check_eq("R11 restart", mclk, 1);

        // R7: gate overrides run
        repeat (40) @(negedge clk);
        while (!mclk) @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
        check_eq("R7 mclk", mclk, 0);
        count_active(1100, n);
        check_eq("R7 held", n, 0);
        gate = 1'b0;
        @(negedge clk);
        check_eq("R11 ungate", mclk, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule